// File: doc/BRIEF.md
# Fault Record Ring Writer

This block turns memory-fault reports from an on-chip fault source into fixed 32-byte records in a circular buffer in system memory. Each report becomes eight consecutive 32-bit word writes. The writes go to the slot selected by a producer pointer that the block owns. Software owns a consumer pointer. It reads records out of memory and then moves its pointer forward through a small register bus. The block raises a pending flag while unread records remain.

Software programs the buffer's 64-bit base address, the number of entries and an enable bit. It reads the producer pointer and a sticky overflow flag. A report that arrives while the ring has no free slot is discarded and the overflow flag is set. The block handles one report at a time: it accepts no new report until all eight words of the current record have been written.

Top module: `fault_ring_writer`

## Requirements
- R1: An accepted report is written as eight words in this order: instance bits 31:0, instance bits 63:32, fault address bits 31:0, fault address bits 63:32, timestamp bits 31:0, timestamp bits 63:32, word six, word seven.
- R2: Word six holds the engine id in bits 7:0 and zeros above it. Word seven holds the following fields: a constant 1 in bit 31, the cluster index in bits 28:24, the hub flag in bit 20, the access type in bits 19:16, the client id in bits 14:8 and the reason code in bits 4:0. All other bits of word seven are zero.
- R3: Word k (k = 0 to 7) of the record for slot n goes to byte address base + 32*n + 4*k.
- R4: The producer pointer advances by one when the eighth word of a record is accepted. It returns to 0 when the advanced value equals the entry count.
- R5: `pending` is high exactly when the buffer is enabled and the consumer pointer differs from the producer pointer.
- R6: The ring is full when the advanced producer pointer (after wrap) equals the consumer pointer. A report accepted while the ring is full and enabled causes no memory write, leaves the producer pointer unchanged and sets the overflow flag.
- R7: A report accepted while the buffer is disabled causes no memory write and does not change the producer pointer or the overflow flag.
- R8: `flt_ready` is high exactly when no record is being written.
- R9: While `mem_wr_valid` is high and `mem_wr_ready` is low, the word's address and data stay unchanged in the following cycle.
- R10: The register map uses word offsets on `reg_addr`. Offset 0 is config: entry count in bits 19:0 and enable in bit 31. Offset 1 is base bits 31:0 and offset 2 is base bits 63:32. Offset 3 is the consumer pointer, which is read-write. Offset 4 is the producer pointer, which is read-only. Offset 5 is status, with overflow in bit 0; writing 1 to bit 0 clears it, but a flag set in the same cycle wins. Other offsets read 0.
- R11: After synchronous reset, both pointers, the enable bit and the overflow flag are 0. `flt_ready` is 1, and `mem_wr_valid` and `pending` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| flt_valid | input | 1 | Fault report offered |
| flt_ready | output | 1 | Block can take a report |
| flt_inst | input | 64 | Instance pointer of the faulting context |
| flt_addr | input | 64 | Faulting address |
| flt_stamp | input | 64 | Timestamp |
| flt_engine | input | 8 | Engine id |
| flt_gpc | input | 5 | Cluster index |
| flt_hub | input | 1 | Hub flag |
| flt_access | input | 4 | Access type |
| flt_client | input | 7 | Client id |
| flt_reason | input | 5 | Reason code |
| mem_wr_valid | output | 1 | Memory word write request |
| mem_wr_ready | input | 1 | Memory accepts the word |
| mem_wr_addr | output | 64 | Byte address of the word |
| mem_wr_data | output | 32 | Word data |
| pending | output | 1 | Unread records exist |

## Verification
On every cycle, the assertions check that the word and address are held under backpressure, that ready and an active write never overlap, that the producer pointer only steps by one or wraps, that a dropped or disabled report starts no write, that overflow stays set until it is cleared, and that pending is low when the buffer is disabled or empty. Only the bench scenarios can show the record's contents and word order, the packing of the info fields, the slot addresses across a wrap, the full condition from real pointer values, and the register readback. The bench checks these against a behavioural queue model while the memory side stalls periodically.

// File: rtl/fault_ring_pkg.sv
package fault_ring_pkg;
    localparam int REC_WORDS  = 8;
    localparam int WORD_IDX_W = $clog2(REC_WORDS);
    localparam int REC_SHIFT  = $clog2(REC_WORDS * 4);
    localparam int BASE_W     = 64;

    typedef struct packed {
        logic [63:0] inst;
        logic [63:0] addr;
        logic [63:0] stamp;
        logic [7:0]  engine;
        logic [4:0]  gpc;
        logic        hub;
        logic [3:0]  access;
        logic [6:0]  client;
        logic [4:0]  reason;
    } fault_rpt_t;

    typedef enum logic [2:0] {
        REG_CFG     = 3'd0,
        REG_BASE_LO = 3'd1,
        REG_BASE_HI = 3'd2,
        REG_GET     = 3'd3,
        REG_PUT     = 3'd4,
        REG_STAT    = 3'd5
    } reg_sel_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_WRITE = 1'b1
    } wr_state_e;

    function automatic logic [31:0] pack_detail(input fault_rpt_t f);
        return {1'b1, 2'b00, f.gpc, 3'b000, f.hub, f.access, 1'b0, f.client, 3'b000, f.reason};
    endfunction

    function automatic logic [31:0] record_word(input fault_rpt_t f, input logic [WORD_IDX_W-1:0] idx);
        logic [31:0] w;
        case (idx)
            3'd0:    w = f.inst[31:0];
            3'd1:    w = f.inst[63:32];
            3'd2:    w = f.addr[31:0];
            3'd3:    w = f.addr[63:32];
            3'd4:    w = f.stamp[31:0];
            3'd5:    w = f.stamp[63:32];
            3'd6:    w = {24'h0, f.engine};
            default: w = pack_detail(f);
        endcase
        return w;
    endfunction
endpackage

// File: rtl/fault_ring_regs.sv
module fault_ring_regs
    import fault_ring_pkg::*;
#(
    parameter int PTR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [PTR_W-1:0]  put_ptr,
    input  logic              ovf_set,
    output logic              enable,
    output logic [PTR_W-1:0]  entry_count,
    output logic [BASE_W-1:0] base_addr,
    output logic [PTR_W-1:0]  get_ptr,
    output logic              overflow
);
    localparam int PAD_W = 31 - PTR_W;

    reg_sel_e sel;
    logic     ovf_clr;
    logic     unused_wdata;

    assign sel          = reg_sel_e'(reg_addr);
    assign ovf_clr      = reg_wr && (sel == REG_STAT) && reg_wdata[0];
    assign unused_wdata = ^reg_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            enable      <= 1'b0;
            entry_count <= '0;
            base_addr   <= '0;
            get_ptr     <= '0;
            overflow    <= 1'b0;
        end else begin
            if (reg_wr) begin
                case (sel)
                    REG_CFG: begin
                        enable      <= reg_wdata[31];
                        entry_count <= reg_wdata[PTR_W-1:0];
                    end
                    REG_BASE_LO: base_addr[31:0]  <= reg_wdata;
                    REG_BASE_HI: base_addr[63:32] <= reg_wdata;
                    REG_GET:     get_ptr          <= reg_wdata[PTR_W-1:0];
                    default: ;
                endcase
            end
            overflow <= ovf_set | (overflow & ~ovf_clr);
        end
    end

    always_comb begin
        case (sel)
            REG_CFG:     reg_rdata = {enable, {PAD_W{1'b0}}, entry_count};
            REG_BASE_LO: reg_rdata = base_addr[31:0];
            REG_BASE_HI: reg_rdata = base_addr[63:32];
            REG_GET:     reg_rdata = {{(32-PTR_W){1'b0}}, get_ptr};
            REG_PUT:     reg_rdata = {{(32-PTR_W){1'b0}}, put_ptr};
            REG_STAT:    reg_rdata = {31'h0, overflow};
            default:     reg_rdata = 32'h0;
        endcase
    end

    // R6 / R10: overflow is sticky until a clearing write
    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (overflow && !(reg_wr && reg_addr == 3'd5 && reg_wdata[0])) |=> overflow);
endmodule

// File: rtl/fault_ring_seq.sv
module fault_ring_seq
    import fault_ring_pkg::*;
#(
    parameter int PTR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [PTR_W-1:0]  entry_count,
    input  logic [BASE_W-1:0] base_addr,
    input  logic [PTR_W-1:0]  get_ptr,
    input  logic              flt_valid,
    input  fault_rpt_t        flt_rpt,
    output logic              flt_ready,
    output logic              mem_wr_valid,
    input  logic              mem_wr_ready,
    output logic [BASE_W-1:0] mem_wr_addr,
    output logic [31:0]       mem_wr_data,
    output logic [PTR_W-1:0]  put_ptr,
    output logic              ovf_set
);
    wr_state_e               state_q;
    fault_rpt_t              rec_q;
    logic [WORD_IDX_W-1:0]   idx_q;
    logic [PTR_W-1:0]        put_q;
    logic [PTR_W-1:0]        put_inc;
    logic [PTR_W-1:0]        put_next;
    logic                    full;
    logic                    accept;
    logic                    take;
    logic                    word_done;
    logic                    last_word;

    assign put_inc   = put_q + PTR_W'(1);
    assign put_next  = (put_inc == entry_count) ? '0 : put_inc;
    assign full      = (put_next == get_ptr);
    assign flt_ready = (state_q == ST_IDLE);
    assign accept    = flt_valid && flt_ready;
    assign take      = accept && enable && !full;
    assign ovf_set   = accept && enable && full;

    assign mem_wr_valid = (state_q == ST_WRITE);
    assign word_done    = mem_wr_valid && mem_wr_ready;
    assign last_word    = (idx_q == WORD_IDX_W'(REC_WORDS - 1));
    assign mem_wr_data  = record_word(rec_q, idx_q);
    assign mem_wr_addr  = base_addr
                        + ({{(BASE_W-PTR_W){1'b0}}, put_q} << REC_SHIFT)
                        + {{(BASE_W-WORD_IDX_W-2){1'b0}}, idx_q, 2'b00};
    assign put_ptr      = put_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            rec_q   <= '0;
            idx_q   <= '0;
            put_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (take) begin
                        rec_q   <= flt_rpt;
                        idx_q   <= '0;
                        state_q <= ST_WRITE;
                    end
                end
                default: begin
                    if (word_done) begin
                        idx_q <= idx_q + WORD_IDX_W'(1);
                        if (last_word) begin
                            put_q   <= put_next;
                            state_q <= ST_IDLE;
                        end
                    end
                end
            endcase
        end
    end

    // R9: word held while memory stalls
    p_wr_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_valid && !mem_wr_ready) |=> (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));
    // R8: no new report while a record is in flight
    p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (rst)
        mem_wr_valid |-> !flt_ready);
    // R4: producer pointer steps by one or wraps to zero
    p_put_step_r4: assert property (@(posedge clk) disable iff (rst)
        (put_q != $past(put_q)) |-> (put_q == $past(put_q) + PTR_W'(1) || put_q == '0));
    // R6: a dropped report starts no write and leaves the pointer alone
    p_drop_r6: assert property (@(posedge clk) disable iff (rst)
        ovf_set |=> (!mem_wr_valid && $stable(put_q)));
    // R7: disabled buffer starts no write
    p_disabled_r7: assert property (@(posedge clk) disable iff (rst)
        (flt_valid && flt_ready && !enable) |=> !mem_wr_valid);
endmodule

// File: rtl/fault_ring_writer.sv
module fault_ring_writer
    import fault_ring_pkg::*;
#(
    parameter int PTR_W = 20
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        flt_valid,
    output logic        flt_ready,
    input  logic [63:0] flt_inst,
    input  logic [63:0] flt_addr,
    input  logic [63:0] flt_stamp,
    input  logic [7:0]  flt_engine,
    input  logic [4:0]  flt_gpc,
    input  logic        flt_hub,
    input  logic [3:0]  flt_access,
    input  logic [6:0]  flt_client,
    input  logic [4:0]  flt_reason,
    output logic        mem_wr_valid,
    input  logic        mem_wr_ready,
    output logic [63:0] mem_wr_addr,
    output logic [31:0] mem_wr_data,
    output logic        pending
);
    fault_rpt_t        rpt;
    logic              enable;
    logic [PTR_W-1:0]  entry_count;
    logic [BASE_W-1:0] base_addr;
    logic [PTR_W-1:0]  get_ptr;
    logic [PTR_W-1:0]  put_ptr;
    logic              ovf_set;
    logic              overflow;
    logic              unused_ovf;

    assign rpt = '{inst: flt_inst, addr: flt_addr, stamp: flt_stamp, engine: flt_engine,
                   gpc: flt_gpc, hub: flt_hub, access: flt_access, client: flt_client,
                   reason: flt_reason};
    assign unused_ovf = overflow;

    fault_ring_regs #(.PTR_W(PTR_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .put_ptr     (put_ptr),
        .ovf_set     (ovf_set),
        .enable      (enable),
        .entry_count (entry_count),
        .base_addr   (base_addr),
        .get_ptr     (get_ptr),
        .overflow    (overflow)
    );

    fault_ring_seq #(.PTR_W(PTR_W)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .enable       (enable),
        .entry_count  (entry_count),
        .base_addr    (base_addr),
        .get_ptr      (get_ptr),
        .flt_valid    (flt_valid),
        .flt_rpt      (rpt),
        .flt_ready    (flt_ready),
        .mem_wr_valid (mem_wr_valid),
        .mem_wr_ready (mem_wr_ready),
        .mem_wr_addr  (mem_wr_addr),
        .mem_wr_data  (mem_wr_data),
        .put_ptr      (put_ptr),
        .ovf_set      (ovf_set)
    );

    assign pending = enable && (get_ptr != put_ptr);

    // R5: nothing pending while disabled or empty
    p_pending_off_r5: assert property (@(posedge clk) disable iff (rst)
        (!enable || get_ptr == put_ptr) |-> !pending);
endmodule

// File: tb/fault_ring_writer_bench.sv
`timescale 1ns/1ps
module fault_ring_writer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        flt_valid = 1'b0;
    logic        flt_ready;
    logic [63:0] flt_inst = '0, flt_addr = '0, flt_stamp = '0;
    logic [7:0]  flt_engine = '0;
    logic [4:0]  flt_gpc = '0;
    logic        flt_hub = 1'b0;
    logic [3:0]  flt_access = '0;
    logic [6:0]  flt_client = '0;
    logic [4:0]  flt_reason = '0;
    logic        mem_wr_valid;
    logic        mem_wr_ready = 1'b1;
    logic [63:0] mem_wr_addr;
    logic [31:0] mem_wr_data;
    logic        pending;

    always #4 clk = ~clk;

    fault_ring_writer u_fault_ring_writer (.*);

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural model
    bit          m_en = 0, m_ovf = 0, m_busy = 0;
    longint      m_cnt = 0, m_get = 0, m_put = 0;
    logic [63:0] m_base = '0;
    int          m_left = 0;
    logic [63:0] qa[$];
    logic [31:0] qd[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic longint wrap_next(input longint p);
        return (p + 1 == m_cnt) ? 0 : p + 1;
    endfunction

    always @(negedge clk) begin
        if (rst) begin
            m_en = 0; m_ovf = 0; m_busy = 0; m_cnt = 0; m_get = 0; m_put = 0;
            m_base = '0; m_left = 0; qa.delete(); qd.delete();
        end else begin
            bit pre_busy;
            bit ovf_clr;
            bit ovf_set;
            pre_busy = m_busy;
            ovf_clr = 0;
            ovf_set = 0;
            chk(flt_ready == !m_busy, "R8", "flt_ready", flt_ready, !m_busy);
            chk(pending == (m_en && m_get != m_put), "R5", "pending", pending, m_en && m_get != m_put);
            chk(mem_wr_valid == m_busy, "R9", "mem_wr_valid", mem_wr_valid, m_busy);
            if (mem_wr_valid && qa.size() > 0) begin
                chk(mem_wr_addr == qa[0], "R3", "word address", mem_wr_addr, qa[0]);
                chk(mem_wr_data == qd[0], "R1", "word data", mem_wr_data, qd[0]);
            end
            if (m_busy && mem_wr_ready) begin
                void'(qa.pop_front());
                void'(qd.pop_front());
                m_left--;
                if (m_left == 0) begin
                    m_put = wrap_next(m_put);
                    m_busy = 0;
                end
            end
            if (flt_valid && !pre_busy && m_en) begin
                if (wrap_next(m_put) == m_get) ovf_set = 1;
                else begin
                    logic [31:0] w [8];
                    w[0] = flt_inst[31:0];  w[1] = flt_inst[63:32];
                    w[2] = flt_addr[31:0];  w[3] = flt_addr[63:32];
                    w[4] = flt_stamp[31:0]; w[5] = flt_stamp[63:32];
                    w[6] = 32'(flt_engine);
                    w[7] = 32'h8000_0000 | (32'(flt_gpc) << 24) | (32'(flt_hub) << 20)
                         | (32'(flt_access) << 16) | (32'(flt_client) << 8) | 32'(flt_reason);
                    for (int k = 0; k < 8; k++) begin
                        qa.push_back(m_base + 64'(m_put) * 32 + 64'(k) * 4);
                        qd.push_back(w[k]);
                    end
                    m_busy = 1;
                    m_left = 8;
                end
            end
            if (reg_wr) begin
                case (reg_addr)
                    3'd0: begin m_en = reg_wdata[31]; m_cnt = longint'(reg_wdata[19:0]); end
                    3'd1: m_base[31:0]  = reg_wdata;
                    3'd2: m_base[63:32] = reg_wdata;
                    3'd3: m_get = longint'(reg_wdata[19:0]);
                    3'd5: ovf_clr = reg_wdata[0];
                    default: ;
                endcase
            end
            m_ovf = ovf_set | (m_ovf & !ovf_clr);
        end
    end

    // memory stalls every third cycle
    initial begin
        int c = 0;
        forever begin
            @(posedge clk); #1;
            mem_wr_ready = (c % 3) != 2;
            c++;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string req);
        @(posedge clk); #1;
        reg_addr = a;
        @(negedge clk); #1;
        chk(reg_rdata == exp, req, "register readback", reg_rdata, exp);
    endtask

    task automatic send(input logic [63:0] inst, input logic [63:0] addr, input logic [63:0] stamp,
                        input logic [7:0] eng, input logic [4:0] gpc, input logic hub,
                        input logic [3:0] acc, input logic [6:0] cli, input logic [4:0] rsn);
        bit ok;
        @(posedge clk); #1;
        flt_valid = 1'b1; flt_inst = inst; flt_addr = addr; flt_stamp = stamp;
        flt_engine = eng; flt_gpc = gpc; flt_hub = hub; flt_access = acc;
        flt_client = cli; flt_reason = rsn;
        do begin
            @(negedge clk);
            ok = flt_ready;
            @(posedge clk); #1;
        end while (!ok);
        flt_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do begin
            @(negedge clk); #1;
        end while (m_busy);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            report();
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk); #1;
        // R11: reset state
        chk(flt_ready == 1'b1, "R11", "reset flt_ready", flt_ready, 1);
        chk(mem_wr_valid == 1'b0, "R11", "reset mem_wr_valid", mem_wr_valid, 0);
        chk(pending == 1'b0, "R11", "reset pending", pending, 0);
        rd(3'd0, 32'h0, "R11");
        rd(3'd4, 32'h0, "R11");
        rd(3'd5, 32'h0, "R11");

        // R10: configuration readback; base 0x1_0000_2000, 4 entries
        wr(3'd1, 32'h0000_2000);
        wr(3'd2, 32'h0000_0001);
        wr(3'd0, 32'h8000_0004);
        rd(3'd0, 32'h8000_0004, "R10");
        rd(3'd1, 32'h0000_2000, "R10");
        rd(3'd2, 32'h0000_0001, "R10");
        rd(3'd6, 32'h0, "R10");

        // R1 R2 R3: three records fill slots 0..2
        send(64'h1111_2222_3333_4444, 64'hAAAA_0000_BBBB_1000, 64'h0000_0009_8765_4321,
             8'h3C, 5'h1F, 1'b1, 4'hA, 7'h7F, 5'h15);
        wait_idle();
        send(64'h0, 64'hFFFF_FFFF_FFFF_F000, 64'h1, 8'hFF, 5'h00, 1'b0, 4'h0, 7'h00, 5'h00);
        wait_idle();
        send(64'hDEAD_BEEF_0000_0001, 64'h55, 64'h77, 8'h01, 5'h0A, 1'b0, 4'h5, 7'h2A, 5'h1F);
        wait_idle();
        rd(3'd4, 32'd3, "R4");

        // R6: ring full (put+1 wraps to get=0) -> dropped, overflow set
        send(64'h9, 64'h9, 64'h9, 8'h9, 5'h9, 1'b1, 4'h9, 7'h9, 5'h9);
        wait_idle();
        rd(3'd5, 32'h1, "R6");
        rd(3'd4, 32'd3, "R6");

        // R10: clear overflow, put is read-only
        wr(3'd5, 32'h1);
        rd(3'd5, 32'h0, "R10");
        wr(3'd4, 32'd7);
        rd(3'd4, 32'd3, "R10");

        // R4: consume two, produce two across the wrap
        wr(3'd3, 32'd2);
        rd(3'd3, 32'd2, "R10");
        send(64'hCAFE, 64'h1234_5678_9ABC_DEF0, 64'h42, 8'h80, 5'h10, 1'b1, 4'h1, 7'h40, 5'h01);
        wait_idle();
        send(64'hF00D, 64'h8, 64'h43, 8'h7F, 5'h01, 1'b0, 4'hF, 7'h01, 5'h10);
        wait_idle();
        rd(3'd4, 32'd1, "R4");
        chk(pending == 1'b1, "R5", "pending after wrap", pending, 1);

        // R7: disabled buffer ignores reports
        wr(3'd0, 32'h0000_0004);
        send(64'h5, 64'h5, 64'h5, 8'h5, 5'h5, 1'b0, 4'h5, 7'h5, 5'h5);
        wait_idle();
        chk(mem_wr_valid == 1'b0, "R7", "no write while disabled", mem_wr_valid, 0);
        chk(pending == 1'b0, "R7", "pending while disabled", pending, 0);
        rd(3'd4, 32'd1, "R7");
        rd(3'd5, 32'h0, "R7");

        // R5: re-enable with get == put -> empty
        wr(3'd3, 32'd1);
        wr(3'd0, 32'h8000_0004);
        @(negedge clk); #1;
        chk(pending == 1'b0, "R5", "pending when empty", pending, 0);

        done = 1;
        report();
    end
endmodule